// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block produces a pulse-width-modulated output whose average duty cycle resolves finer than one period of its fast counter. A single fast counter drives two comparators that share one compare value. The strict comparator is high while the count is below that value. The inclusive comparator is high while the count is at or below it. The inclusive pulse is therefore exactly one clock longer. A slow control counter steps once each time the fast counter wraps and selects the inclusive channel for a programmable number of fast periods in every control period. This adds low-order bits of resolution while the output keeps repeating at the fast-counter rate.

The user writes a pulse-width word together with a load strobe. The word goes into a shadow register and becomes active only when both counters wrap together. While the enable is low, both counters sit at zero, the output stays low, and the shadow value is copied straight into the active register. When the enable rises, both counters start from zero on the same clock. With the default widths, a 12 MHz clock gives a 46.875 kHz output, and the average duty cycle is the pulse-width word divided by 65536.

Top module: `dither_pwm`

## Requirements
- R1: While reset is high at a clock edge, the output is low on the next cycle, and the shadow and active pulse-width values are cleared to zero.
- R2: The fast counter counts 0 to 2^FAST_W-1 and wraps. For a coarse field U, the strict channel is high for U clocks of each fast period and the inclusive channel for U+1 clocks (capped at the period), so the inclusive pulse always contains the strict pulse.
- R3: The control counter advances only on the clock where the fast counter wraps, so one control period lasts 2^CTRL_W fast periods.
- R4: The output follows the inclusive channel while the control count is below the fine field L, and the strict channel otherwise. After a start, the first fast period therefore holds U+1 high clocks when L>0 and U when L=0.
- R5: Over any full control period of constant setting, the output is high for 2^CTRL_W·U + L clocks, which equals the pulse-width word. This covers 65535 (all high but one clock) and 0x8003 (32771).
- R6: Bits [PW_W-1:CTRL_W] of the pulse-width word (the upper 8 by default) form the coarse field U. Bits [CTRL_W-1:0] (the lower 8) form the fine field L. Over the first four fast periods after a start, the high count is 4·U + min(4, L).
- R7: A word captured on the load strobe while running does not change the output until both counters wrap together. The whole control period in progress keeps the old value, and the next one uses the new value.
- R8: When the enable is low at a clock edge, the output is low on the next cycle and both counters return to zero. The shadow value becomes active while the enable is low.
- R9: The output is registered. In the cycle after the first edge that samples the enable high, the output reflects count zero of both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds counters at zero and output low |
| load | input | 1 | Captures pw_in into the shadow register |
| pw_in | input | FAST_W+CTRL_W | Pulse-width word: coarse field in the upper bits, fine field in the lower bits |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Two events can fall on the same clock: the joint wrap of both counters, where the active value is replaced, and the load strobe, which writes the shadow. The bench loads a new word partway through a running 65536-clock control period. It then counts output-high clocks over that period and over the one that follows, without a gap. The first total must still equal the old word and the second must equal the new one. Any early or late swap shows up as a total that mixes the two values.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Which fast channel drives the output
    typedef enum logic {
        CH_STRICT = 1'b0,
        CH_INCL   = 1'b1
    } ch_sel_e;

    function automatic logic mux_pick(ch_sel_e sel, logic strict_ch, logic incl_ch);
        return (sel == CH_INCL) ? incl_ch : strict_ch;
    endfunction

endpackage

// File: rtl/dpwm_fast_cmp.sv
module dpwm_fast_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] cmp_i,
    output logic         wrap_o,
    output logic         strict_o,
    output logic         incl_o
);
    localparam logic [W-1:0] LAST = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        wrap_o   = en_i && (cnt_q == LAST);
        strict_o = (cnt_q <  cmp_i);
        incl_o   = (cnt_q <= cmp_i);
    end

    always_comb begin
        if (!rst) begin
            AST_INCL_COVERS: assert (!strict_o || incl_o); // R2
        end
    end

    AST_FAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en_i && cnt_q == LAST) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/dpwm_ctrl_pwm.sv
module dpwm_ctrl_pwm
    import dpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         step_i,
    input  logic [W-1:0] cmp_i,
    output ch_sel_e      sel_o,
    output logic         last_o
);
    localparam logic [W-1:0] LAST = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) cnt_q <= '0;
        else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        sel_o  = (cnt_q < cmp_i) ? CH_INCL : CH_STRICT;
        last_o = (cnt_q == LAST);
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en_i && !step_i) |=> $stable(cnt_q)); // R3

    AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
    import dpwm_pkg::*;
#(
    parameter int FAST_W = 8,
    parameter int CTRL_W = 8,
    localparam int PW_W  = FAST_W + CTRL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            load,
    input  logic [PW_W-1:0] pw_in,
    output logic            pwm_o
);
    typedef struct packed {
        logic [FAST_W-1:0] coarse;
        logic [CTRL_W-1:0] fine;
    } width_t;

    width_t  pend_q;
    width_t  act_q;
    logic    fast_wrap;
    logic    ch_strict;
    logic    ch_incl;
    logic    ctrl_last;
    logic    joint_wrap;
    ch_sel_e ctrl_sel;

    // Shadow register: written by the user at any time
    always_ff @(posedge clk) begin
        if (rst)       pend_q <= '0;
        else if (load) pend_q <= width_t'(pw_in);
    end

    assign joint_wrap = fast_wrap && ctrl_last;

    // Active register: swapped only at a joint wrap or while idle
    always_ff @(posedge clk) begin
        if (rst)                      act_q <= '0;
        else if (!en || joint_wrap)   act_q <= pend_q;
    end

    dpwm_fast_cmp #(.W(FAST_W)) u_fast (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .cmp_i    (act_q.coarse),
        .wrap_o   (fast_wrap),
        .strict_o (ch_strict),
        .incl_o   (ch_incl)
    );

    dpwm_ctrl_pwm #(.W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en),
        .step_i (fast_wrap),
        .cmp_i  (act_q.fine),
        .sel_o  (ctrl_sel),
        .last_o (ctrl_last)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) pwm_o <= 1'b0;
        else            pwm_o <= mux_pick(ctrl_sel, ch_strict, ch_incl);
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !joint_wrap) |=> $stable(act_q)); // R7

    AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_o); // R8

    AST_RST_LOW: assert property (@(posedge clk)
        rst |=> (!pwm_o && act_q == '0)); // R1

endmodule

// File: tb/dither_pwm_test.sv
module dither_pwm_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] pw_in = '0;
    logic        pwm_o;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dither_pwm uut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .load  (load),
        .pw_in (pw_in),
        .pwm_o (pwm_o)
    );

    // Pulse width, high clocks in first fast period, high clocks in first four
    localparam int NV = 9;
    localparam logic [15:0] VEC_PW [NV] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100,
        16'h0101, 16'h0102, 16'h7F03, 16'hFFFF, 16'h0003};
    localparam int VEC_E1 [NV] = '{0, 1, 1, 1, 2, 2, 128, 256, 1};
    localparam int VEC_E4 [NV] = '{0, 1, 4, 4, 5, 6, 511, 1024, 3};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o) h++;
        end
    endtask

    // Stop, load a value while idle, start again from zero
    task automatic restart(input logic [15:0] v);
        @(negedge clk); en = 1'b0; load = 1'b1; pw_in = v;
        @(negedge clk); load = 1'b0;
        @(negedge clk); en = 1'b1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int h1, h4, hw;
        repeat (3) @(negedge clk);
        chk("R1 reset output low", int'(pwm_o), 0);
        rst = 1'b0;

        // Table walk: R4 first period, R6 field split over four periods, R9 start alignment
        for (int k = 0; k < NV; k++) begin
            restart(VEC_PW[k]);
            count_high(256, h1);
            chk($sformatf("R4 first period pw=%h", VEC_PW[k]), h1, VEC_E1[k]);
            count_high(768, h4);
            chk($sformatf("R6 R9 four periods pw=%h", VEC_PW[k]), h1 + h4, VEC_E4[k]);
        end

        // R2: coarse 3, fine 0 -> every fast period exactly 3 high clocks
        restart(16'h0300);
        count_high(256, h1);
        chk("R2 strict width", h1, 3);
        // R2/R4: coarse 3, fine 1 -> first period 4, second period 3
        restart(16'h0301);
        count_high(256, h1);
        chk("R2 inclusive width", h1, 4);
        count_high(256, h1);
        chk("R3 control stepped once per wrap", h1, 3);

        // R8: disable forces low
        restart(16'hFFFF);
        count_high(100, h1);
        @(negedge clk); en = 1'b0;
        count_high(1, h1);
        chk("R8 low after disable", h1, 0);
        count_high(50, h1);
        chk("R8 stays low while disabled", h1, 0);

        // R5 and R7: full period at 65535, new word loaded midway, next period 0x8003
        restart(16'hFFFF);
        hw = 0;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            if (pwm_o) hw++;
            if (i == 1000) begin load = 1'b1; pw_in = 16'h8003; end
            if (i == 1001) load = 1'b0;
        end
        chk("R5 R7 full period keeps old value 65535", hw, 65535);
        count_high(65536, hw);
        chk("R5 R7 next period uses new value 0x8003", hw, 32771);

        // R1: reset while running clears the active value
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 output low after reset", int'(pwm_o), 0);
        count_high(512, h1);
        chk("R1 active value cleared", h1, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule